// File: doc/BRIEF.md
# SDRAM Command Spacing and Refresh Pacing Monitor

This block sits beside an SDRAM command scheduler and watches the command that is actually issued on every clock, together with its bank number. From that stream it keeps, for every bank, a set of countdown timers that say whether an activate, a column access (read or write) or a precharge may legally be issued in the current cycle. A few chip-wide timers cover the activate-to-activate spacing across banks and the quiet time after an auto refresh or a self-refresh exit. The scheduler reads the per-bank permission flags and picks only commands whose flag is high.

All spacing limits are given as nanosecond parameters and turned into whole clock counts, rounded up, from a clock-period parameter at elaboration time. The longest time a row may stay open is rounded down instead, so a warning never comes late. A separate pacer splits the refresh window over the row count and raises one refresh request per interval. It keeps a saturating backlog of owed refreshes, which every auto refresh pays back by one. A command issued while its permission flag is low latches a sticky violation flag and the bank it targeted.

Top module: `sdram_timing_guard`

## Requirements
- R1: After reset every bank is closed. `act_ok_o` is all ones. `rw_ok_o` and `pre_ok_o` are all zeros. `ref_ok_o` is 1. `row_overdue_o`, `refresh_req_o`, `refresh_backlog_o`, `backlog_overflow_o` and `violation_o` are all 0. Command codes on `cmd_i`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh exit, 7 treated as a no-op.
- R2: An activate to bank b in cycle t makes `rw_ok_o[b]` high first in cycle t+ceil(tRCD/tCK), and low in every cycle from t+1 up to that point.
- R3: `pre_ok_o[b]` is high only while bank b is open. It rises in the first cycle that is at least ceil(tRAS/tCK) after the activate and at least 1+ceil(tWR_ns/tCK) after the last write to b.
- R4: After a precharge, `act_ok_o[b]` for that bank rises in the first cycle that is at least ceil(tRC/tCK) after its last activate and at least ceil(tRP/tCK) after the precharge. It is low while the bank is open.
- R5: An activate to any bank in cycle t holds `act_ok_o` low for every bank until cycle t+ceil(tRRD/tCK).
- R6: An auto refresh in cycle t holds all permission flags low until cycle t+ceil(tRFC/tCK). A self-refresh exit does the same until t+ceil(tXSR/tCK).
- R7: `ref_ok_o` is high only when every bank is closed, every bank meets its own tRC and tRP activate spacing, and no tRFC or tXSR window is running.
- R8: `row_overdue_o[b]` goes high in cycle t+floor(tRASmax/tCK)+1 after an activate in cycle t, if bank b is still open by then. It is low in the cycle before that.
- R9: `refresh_backlog_o` rises by one every floor(window/(rows·tCK)) cycles. An auto refresh lowers it by one in the next cycle. A tick and a refresh in the same cycle leave it unchanged. `refresh_req_o` is high exactly while the backlog is non-zero.
- R10: The backlog saturates at BACKLOG_MAX (8). `backlog_overflow_o` is set, and stays set, in the cycle the backlog reaches that value.
- R11: A command whose permission flag is low in its issue cycle sets `violation_o` in the next cycle. `violation_bank_o` takes that command's bank. Both hold until reset, and later violations do not change them. No-op, self-refresh exit and code 7 never count as violations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command issued this cycle (codes in R1) |
| bank_i | input | BANK_W | Bank of the issued command |
| act_ok_o | output | NUM_BANKS | Activate allowed, per bank |
| rw_ok_o | output | NUM_BANKS | Read or write allowed, per bank |
| pre_ok_o | output | NUM_BANKS | Precharge allowed, per bank |
| ref_ok_o | output | 1 | Auto refresh allowed |
| row_overdue_o | output | NUM_BANKS | Row open longer than the maximum |
| refresh_req_o | output | 1 | At least one refresh owed |
| refresh_backlog_o | output | BL_W | Number of refreshes owed |
| backlog_overflow_o | output | 1 | Sticky: backlog reached its cap |
| violation_o | output | 1 | Sticky: illegal command seen |
| violation_bank_o | output | BANK_W | Bank of the first illegal command |

## Verification
Every permission flag is registered state, so a command in cycle t first shows its effect in cycle t+1. A spacing of N clocks releases its flag exactly in cycle t+N. The bench stamps each issued command with its cycle number. It checks each limit in both the last blocked cycle and the first allowed cycle. It also compares all flags every cycle during a random legal command stream against a model built from those time stamps. The row-age flag is due one cycle after the rounded-down limit. Backlog changes appear the cycle after a pacer tick or refresh. The violation latch is sampled the cycle after the offending command.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_SRX = 3'd6
  } sg_cmd_e;

  function automatic int ns_to_cyc_ceil(input longint ns, input longint tck_ps);
    return int'((ns * 1000 + tck_ps - 1) / tck_ps);
  endfunction

  function automatic int ns_to_cyc_floor(input longint ns, input longint tck_ps);
    return int'((ns * 1000) / tck_ps);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sg_bank_timer.sv
module sg_bank_timer #(
  parameter int CW        = 4,
  parameter int OW        = 15,
  parameter int C_RCD     = 2,
  parameter int C_RAS     = 5,
  parameter int C_RC      = 8,
  parameter int C_RP      = 2,
  parameter int C_WR      = 2,
  parameter int C_RAS_MAX = 16000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_i,
  input  logic pre_i,
  output logic open_o,
  output logic act_clear_o,
  output logic rw_ready_o,
  output logic pre_ready_o,
  output logic overdue_o
);

  localparam logic [CW-1:0] RCD_L = CW'(C_RCD - 1);
  localparam logic [CW-1:0] RAS_L = CW'(C_RAS - 1);
  localparam logic [CW-1:0] RC_L  = CW'(C_RC - 1);
  localparam logic [CW-1:0] RP_L  = CW'(C_RP - 1);
  localparam logic [CW-1:0] WR_L  = CW'(C_WR - 1);
  localparam logic [OW-1:0] AGE_SAT = OW'(C_RAS_MAX + 1);

  logic          open_q;
  logic [CW-1:0] rcd_q, ras_q, act_q, wr_q;
  logic [OW-1:0] age_q;
  logic [CW-1:0] act_dec;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v != '0) ? v - 1'b1 : v;
  endfunction

  assign act_dec = dec(act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      act_q  <= '0;
      wr_q   <= '0;
      age_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      rcd_q  <= RCD_L;
      ras_q  <= RAS_L;
      act_q  <= RC_L;
      wr_q   <= dec(wr_q);
      age_q  <= OW'(1);
    end else begin
      rcd_q <= dec(rcd_q);
      ras_q <= dec(ras_q);
      wr_q  <= wr_i ? WR_L : dec(wr_q);
      if (pre_i) begin
        open_q <= 1'b0;
        act_q  <= (act_dec > RP_L) ? act_dec : RP_L;  // later of tRC and tRP
      end else begin
        act_q <= act_dec;
      end
      if (open_q && age_q != AGE_SAT) age_q <= age_q + 1'b1;
    end
  end

  assign open_o      = open_q;
  assign act_clear_o = (act_q == '0);
  assign rw_ready_o  = open_q && (rcd_q == '0);
  assign pre_ready_o = open_q && (ras_q == '0) && (wr_q == '0);
  assign overdue_o   = open_q && (age_q > OW'(C_RAS_MAX));

endmodule

// File: rtl/sg_refresh_pacer.sv
module sg_refresh_pacer #(
  parameter int C_REFI      = 1041,
  parameter int BACKLOG_MAX = 8,
  localparam int TW   = (C_REFI > 1) ? $clog2(C_REFI) : 1,
  localparam int BL_W = $clog2(BACKLOG_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  output logic [BL_W-1:0] backlog_o,
  output logic            overflow_o
);

  localparam logic [TW-1:0]   TMR_LAST = TW'(C_REFI - 1);
  localparam logic [BL_W-1:0] BL_CAP   = BL_W'(BACKLOG_MAX);

  logic [TW-1:0]   tmr_q;
  logic [BL_W-1:0] bl_q, bl_d;
  logic            ovf_q, tick, pay;

  assign tick = (tmr_q == TMR_LAST);
  assign pay  = ref_i && (bl_q != '0);

  always_comb begin
    bl_d = bl_q;
    if (tick && !pay && bl_q != BL_CAP) bl_d = bl_q + 1'b1;
    else if (pay && !tick)              bl_d = bl_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      bl_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      bl_q  <= bl_d;
      if (bl_d == BL_CAP) ovf_q <= 1'b1;
    end
  end

  assign backlog_o  = bl_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int T_CK_PS       = 7500,
  parameter int T_RCD_NS      = 15,
  parameter int T_RAS_NS      = 37,
  parameter int T_RAS_MAX_NS  = 120000,
  parameter int T_RC_NS       = 60,
  parameter int T_RRD_NS      = 14,
  parameter int T_RP_NS       = 15,
  parameter int T_RFC_NS      = 66,
  parameter int T_WR_NS       = 7,
  parameter int T_XSR_NS      = 67,
  parameter int REF_WINDOW_NS = 64000000,
  parameter int REF_ROWS      = 8192,
  parameter int BACKLOG_MAX   = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BL_W   = $clog2(BACKLOG_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic [NUM_BANKS-1:0] rw_ok_o,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic                 ref_ok_o,
  output logic [NUM_BANKS-1:0] row_overdue_o,
  output logic                 refresh_req_o,
  output logic [BL_W-1:0]      refresh_backlog_o,
  output logic                 backlog_overflow_o,
  output logic                 violation_o,
  output logic [BANK_W-1:0]    violation_bank_o
);

  localparam int C_RCD     = ns_to_cyc_ceil(T_RCD_NS, T_CK_PS);
  localparam int C_RAS     = ns_to_cyc_ceil(T_RAS_NS, T_CK_PS);
  localparam int C_RC      = ns_to_cyc_ceil(T_RC_NS, T_CK_PS);
  localparam int C_RRD     = ns_to_cyc_ceil(T_RRD_NS, T_CK_PS);
  localparam int C_RP      = ns_to_cyc_ceil(T_RP_NS, T_CK_PS);
  localparam int C_RFC     = ns_to_cyc_ceil(T_RFC_NS, T_CK_PS);
  localparam int C_WR      = 1 + ns_to_cyc_ceil(T_WR_NS, T_CK_PS);
  localparam int C_XSR     = ns_to_cyc_ceil(T_XSR_NS, T_CK_PS);
  localparam int C_RAS_MAX = ns_to_cyc_floor(T_RAS_MAX_NS, T_CK_PS);
  localparam int C_REFI    =
      int'((longint'(REF_WINDOW_NS) * 1000) / (longint'(REF_ROWS) * T_CK_PS));
  localparam int CW  = $clog2(max_of(max_of(max_of(C_RCD, C_RAS), max_of(C_RC, C_RP)), C_WR) + 1);
  localparam int GW  = $clog2(max_of(max_of(C_RRD, C_RFC), C_XSR) + 1);
  localparam int OW  = $clog2(C_RAS_MAX + 2);

  logic [NUM_BANKS-1:0] open_w, act_clear_w, rw_ready_w, pre_ready_w;
  logic [GW-1:0]        rrd_q, busy_q;
  logic                 busy_clear, legal;
  logic                 viol_q;
  logic [BANK_W-1:0]    vbank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));
    sg_bank_timer #(
      .CW(CW), .OW(OW), .C_RCD(C_RCD), .C_RAS(C_RAS), .C_RC(C_RC),
      .C_RP(C_RP), .C_WR(C_WR), .C_RAS_MAX(C_RAS_MAX)
    ) i_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (hit && cmd_i == CMD_ACT),
      .wr_i       (hit && cmd_i == CMD_WR),
      .pre_i      (hit && cmd_i == CMD_PRE),
      .open_o     (open_w[b]),
      .act_clear_o(act_clear_w[b]),
      .rw_ready_o (rw_ready_w[b]),
      .pre_ready_o(pre_ready_w[b]),
      .overdue_o  (row_overdue_o[b])
    );
    assign act_ok_o[b] = !open_w[b] && act_clear_w[b] && (rrd_q == '0) && busy_clear;
    assign rw_ok_o[b]  = rw_ready_w[b] && busy_clear;
    assign pre_ok_o[b] = pre_ready_w[b] && busy_clear;
  end

  assign busy_clear = (busy_q == '0);
  assign ref_ok_o   = (open_w == '0) && (&act_clear_w) && busy_clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q  <= '0;
      busy_q <= '0;
    end else begin
      if (cmd_i == CMD_ACT)  rrd_q <= GW'(C_RRD - 1);
      else if (rrd_q != '0)  rrd_q <= rrd_q - 1'b1;
      if (cmd_i == CMD_REF)      busy_q <= GW'(C_RFC - 1);
      else if (cmd_i == CMD_SRX) busy_q <= GW'(C_XSR - 1);
      else if (busy_q != '0)     busy_q <= busy_q - 1'b1;
    end
  end

  always_comb begin
    case (cmd_i)
      CMD_ACT:        legal = act_ok_o[bank_i];
      CMD_RD, CMD_WR: legal = rw_ok_o[bank_i];
      CMD_PRE:        legal = pre_ok_o[bank_i];
      CMD_REF:        legal = ref_ok_o;
      default:        legal = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q  <= 1'b0;
      vbank_q <= '0;
    end else if (!legal && !viol_q) begin
      viol_q  <= 1'b1;
      vbank_q <= bank_i;
    end
  end

  assign violation_o      = viol_q;
  assign violation_bank_o = vbank_q;

  sg_refresh_pacer #(.C_REFI(C_REFI), .BACKLOG_MAX(BACKLOG_MAX)) i_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (cmd_i == CMD_REF),
    .backlog_o (refresh_backlog_o),
    .overflow_o(backlog_overflow_o)
  );

  assign refresh_req_o = (refresh_backlog_o != '0);

endmodule

// File: rtl/sdram_timing_guard_chk.sv
module sdram_timing_guard_chk
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_W      = 2,
  parameter int BL_W        = 4,
  parameter int BACKLOG_MAX = 8,
  parameter int C_RCD       = 2,
  parameter int C_RRD       = 2,
  parameter int C_RFC       = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [NUM_BANKS-1:0] act_ok_o,
  input logic [NUM_BANKS-1:0] rw_ok_o,
  input logic                 ref_ok_o,
  input logic [BL_W-1:0]      refresh_backlog_o,
  input logic                 backlog_overflow_o,
  input logic                 violation_o,
  input logic [BANK_W-1:0]    violation_bank_o
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    if (C_RCD > 1) begin : g_rcd
      a_r2_rcd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_ACT && bank_i == BANK_W'(b)) |=> !rw_ok_o[b]);
    end
    a_r4_open_blocks_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rw_ok_o[b] |-> !act_ok_o[b]);
  end

  if (C_RRD > 1) begin : g_rrd
    a_r5_rrd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_ACT) |=> (act_ok_o == '0));
  end

  if (C_RFC > 1) begin : g_rfc
    a_r6_rfc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_REF) |=> (act_ok_o == '0 && !ref_ok_o));
  end

  a_r7_ref_needs_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok_o |-> (rw_ok_o == '0));

  a_r10_backlog_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_backlog_o <= BL_W'(BACKLOG_MAX));

  a_r10_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backlog_overflow_o |=> backlog_overflow_o);

  a_r11_violation_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> (violation_o && $stable(violation_bank_o)));

endmodule

bind sdram_timing_guard sdram_timing_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BL_W(BL_W), .BACKLOG_MAX(BACKLOG_MAX),
  .C_RCD(C_RCD), .C_RRD(C_RRD), .C_RFC(C_RFC)
) i_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cmd_i             (cmd_i),
  .bank_i            (bank_i),
  .act_ok_o          (act_ok_o),
  .rw_ok_o           (rw_ok_o),
  .ref_ok_o          (ref_ok_o),
  .refresh_backlog_o (refresh_backlog_o),
  .backlog_overflow_o(backlog_overflow_o),
  .violation_o       (violation_o),
  .violation_bank_o  (violation_bank_o)
);

// File: tb/test_sdram_timing_guard.sv
`timescale 1ns/1ps
module test_sdram_timing_guard;

  localparam int NB    = 4;
  localparam int TCK   = 8000;
  localparam int NEVER = -1000000;

  function automatic int cy(input int ns);
    return (ns * 1000 + TCK - 1) / TCK;
  endfunction

  localparam int E_RCD = cy(15), E_RAS = cy(37), E_RC = cy(60), E_RRD = cy(14);
  localparam int E_RP = cy(15), E_RFC = cy(66), E_WR = 1 + cy(7), E_XSR = cy(67);
  localparam int E_RAS_MAX = 120000 * 1000 / TCK;
  localparam int E_REFI = int'((64'd64000000 * 1000) / (64'd8192 * TCK));

  logic clk = 0, rst_ni = 0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [NB-1:0] act_ok, rw_ok, pre_ok, overdue;
  logic ref_ok, ref_req, ovf, viol;
  logic [3:0] backlog;
  logic [1:0] vbank;

  int cyc = 0, tests = 0, fails = 0;
  int t_act[NB], t_pre[NB], t_wr[NB];
  int t_any_act, t_ref, t_srx;
  bit open_m[NB];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_timing_guard #(.NUM_BANKS(NB), .T_CK_PS(TCK)) i_sdram_timing_guard (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .bank_i(bank),
    .act_ok_o(act_ok), .rw_ok_o(rw_ok), .pre_ok_o(pre_ok), .ref_ok_o(ref_ok),
    .row_overdue_o(overdue), .refresh_req_o(ref_req), .refresh_backlog_o(backlog),
    .backlog_overflow_o(ovf), .violation_o(viol), .violation_bank_o(vbank));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic goto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      t_act[b] = NEVER; t_pre[b] = NEVER; t_wr[b] = NEVER; open_m[b] = 0;
    end
    t_any_act = NEVER; t_ref = NEVER; t_srx = NEVER;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; cmd = 3'd0; bank = 2'd0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    model_clear();
  endtask

  // drive in cycle c, return in cycle c+1 with a no-op driven
  task automatic issue_at(input int c, input logic [2:0] k, input logic [1:0] b);
    goto(c);
    cmd = k; bank = b;
    @(negedge clk);
    cmd = 3'd0;
  endtask

  function automatic bit busy_clear();
    return (cyc - t_ref >= E_RFC) && (cyc - t_srx >= E_XSR);
  endfunction
  function automatic bit exp_act(input int b);
    return !open_m[b] && cyc - t_act[b] >= E_RC && cyc - t_pre[b] >= E_RP &&
           cyc - t_any_act >= E_RRD && busy_clear();
  endfunction
  function automatic bit exp_rw(input int b);
    return open_m[b] && cyc - t_act[b] >= E_RCD && busy_clear();
  endfunction
  function automatic bit exp_pre(input int b);
    return open_m[b] && cyc - t_act[b] >= E_RAS && cyc - t_wr[b] >= E_WR && busy_clear();
  endfunction
  function automatic bit exp_ref();
    bit r = busy_clear();
    for (int b = 0; b < NB; b++)
      if (open_m[b] || cyc - t_act[b] < E_RC || cyc - t_pre[b] < E_RP) r = 0;
    return r;
  endfunction
  function automatic bit exp_over(input int b);
    return open_m[b] && (cyc - t_act[b] > E_RAS_MAX);
  endfunction

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0, c1, c2;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    check("R1 act_ok", int'(act_ok), 15);
    check("R1 rw_ok", int'(rw_ok), 0);
    check("R1 pre_ok", int'(pre_ok), 0);
    check("R1 ref_ok", int'(ref_ok), 1);
    check("R1 flags", int'({overdue, ref_req, ovf, viol}), 0);
    check("R1 backlog", int'(backlog), 0);

    // random legal stream compared every cycle against time-stamp model
    for (int i = 0; i < 4000; i++) begin
      int k, b;
      bit ok;
      logic [NB-1:0] ea, er, ep, eo;
      for (int j = 0; j < NB; j++) begin
        ea[j] = exp_act(j); er[j] = exp_rw(j); ep[j] = exp_pre(j); eo[j] = exp_over(j);
      end
      check("R2 rw_ok random", int'(rw_ok), int'(er));
      check("R3 pre_ok random", int'(pre_ok), int'(ep));
      check("R4 R5 R6 act_ok random", int'(act_ok), int'(ea));
      check("R7 ref_ok random", int'(ref_ok), int'(exp_ref()));
      check("R8 overdue random", int'(overdue), int'(eo));
      k = $urandom_range(0, 9);
      b = $urandom_range(0, NB - 1);
      ok = 0;
      case (k)
        1, 2: ok = exp_act(b);
        3, 4: ok = exp_rw(b);
        5:    ok = exp_rw(b);
        6, 7: ok = exp_pre(b);
        8:    ok = exp_ref();
        9:    ok = exp_ref() && ($urandom_range(0, 3) == 0);
        default: ok = 0;
      endcase
      if (ok) begin
        case (k)
          1, 2: begin cmd = 3'd1; open_m[b] = 1; t_act[b] = cyc; t_any_act = cyc; end
          3, 4: cmd = 3'd2;
          5:    begin cmd = 3'd3; t_wr[b] = cyc; end
          6, 7: begin cmd = 3'd4; open_m[b] = 0; t_pre[b] = cyc; end
          8:    begin cmd = 3'd5; t_ref = cyc; end
          default: begin cmd = 3'd6; t_srx = cyc; end
        endcase
        bank = 2'(b);
      end else cmd = 3'd0;
      @(negedge clk);
    end
    cmd = 3'd0;
    check("R11 no violation in legal stream", int'(viol), 0);

    // directed spacing: R2 R3 R4
    do_reset();
    c0 = cyc + 1;
    issue_at(c0, 3'd1, 2'd0);
    goto(c0 + E_RCD - 1); check("R2 rw blocked before tRCD", int'(rw_ok[0]), 0);
    goto(c0 + E_RCD);     check("R2 rw allowed at tRCD", int'(rw_ok[0]), 1);
    issue_at(c0 + 4, 3'd3, 2'd0);
    goto(c0 + 4 + E_WR - 1);
    check("R3 pre blocked by write recovery", int'(pre_ok[0]), 0);
    goto(c0 + 4 + E_WR);  check("R3 pre allowed after tWR", int'(pre_ok[0]), 1);
    c1 = c0 + E_RC - 1;   // precharge late enough that tRP decides
    issue_at(c1, 3'd4, 2'd0);
    goto(c1 + E_RP - 1);  check("R4 act blocked during tRP", int'(act_ok[0]), 0);
    goto(c1 + E_RP);      check("R4 act allowed after tRP", int'(act_ok[0]), 1);

    // R3 tRAS dominates; R4 tRC dominates
    c0 = cyc + 1;
    issue_at(c0, 3'd1, 2'd1);
    goto(c0 + E_RAS - 1); check("R3 pre blocked before tRAS", int'(pre_ok[1]), 0);
    goto(c0 + E_RAS);     check("R3 pre allowed at tRAS", int'(pre_ok[1]), 1);
    issue_at(c0 + E_RAS, 3'd4, 2'd1);
    goto(c0 + E_RC - 1);  check("R4 act blocked before tRC", int'(act_ok[1]), 0);
    goto(c0 + E_RC);      check("R4 act allowed at tRC", int'(act_ok[1]), 1);

    // R5 cross-bank spacing
    c0 = cyc + 1;
    issue_at(c0, 3'd1, 2'd2);
    goto(c0 + E_RRD - 1); check("R5 other bank blocked", int'(act_ok[3]), 0);
    goto(c0 + E_RRD);     check("R5 other bank allowed", int'(act_ok[3]), 1);
    check("R7 ref blocked with open bank", int'(ref_ok), 0);
    issue_at(c0 + E_RAS, 3'd4, 2'd2);
    goto(c0 + E_RC - 1);  check("R7 ref blocked before tRC", int'(ref_ok), 0);
    goto(c0 + E_RC);      check("R7 ref allowed when idle", int'(ref_ok), 1);

    // R6 refresh and self-refresh exit windows
    c0 = cyc + 1;
    issue_at(c0, 3'd5, 2'd0);
    goto(c0 + E_RFC - 1); check("R6 act blocked in tRFC", int'(act_ok), 0);
    goto(c0 + E_RFC);     check("R6 act allowed after tRFC", int'(act_ok), 15);
    c0 = cyc + 1;
    issue_at(c0, 3'd6, 2'd0);
    goto(c0 + E_XSR - 1); check("R6 ref blocked in tXSR", int'(ref_ok), 0);
    goto(c0 + E_XSR);     check("R6 ref allowed after tXSR", int'(ref_ok), 1);
    check("R11 srx is not a violation", int'(viol), 0);

    // R8 maximum row open time
    c0 = cyc + 1;
    issue_at(c0, 3'd1, 2'd3);
    goto(c0 + E_RAS_MAX);     check("R8 not overdue at limit", int'(overdue[3]), 0);
    goto(c0 + E_RAS_MAX + 1); check("R8 overdue past limit", int'(overdue[3]), 1);
    issue_at(cyc, 3'd4, 2'd3);
    check("R8 overdue cleared by precharge", int'(overdue[3]), 0);

    // R11 violation latch
    do_reset();
    issue_at(cyc, 3'd7, 2'd1);
    check("R11 code 7 ignored", int'(viol), 0);
    issue_at(cyc, 3'd2, 2'd3);
    check("R11 violation set", int'(viol), 1);
    check("R11 violation bank", int'(vbank), 3);
    issue_at(cyc, 3'd4, 2'd1);
    check("R11 first bank kept", int'(vbank), 3);

    // R9 refresh pacing
    do_reset();
    while (backlog != 4'd1) @(negedge clk);
    c1 = cyc;
    check("R9 request with backlog", int'(ref_req), 1);
    while (backlog != 4'd2) @(negedge clk);
    c2 = cyc;
    check("R9 interval", c2 - c1, E_REFI);
    issue_at(c2 + 5, 3'd5, 2'd0);
    check("R9 refresh pays one", int'(backlog), 1);
    issue_at(c2 + E_REFI - 1, 3'd5, 2'd0);
    check("R9 tick and refresh cancel", int'(backlog), 1);
    issue_at(c2 + E_REFI + 20, 3'd5, 2'd0);
    check("R9 backlog cleared", int'(backlog), 0);
    check("R9 request drops", int'(ref_req), 0);

    // R10 saturation
    do_reset();
    while (backlog != 4'd7) @(negedge clk);
    check("R10 no overflow below cap", int'(ovf), 0);
    while (backlog != 4'd8) @(negedge clk);
    check("R10 overflow at cap", int'(ovf), 1);
    c0 = cyc;
    goto(c0 + E_REFI + 2);
    check("R10 backlog saturates", int'(backlog), 8);
    check("R10 overflow sticky", int'(ovf), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule